// File: doc/BRIEF.md
# Flag-Setting ALU with Condition Check

This block is the integer execute stage of a small 32-bit core. Each cycle it takes an opcode, a first operand and an already shifted second operand, together with the shifter's carry-out. It returns the combinational result and a write-enable for the destination. It also holds four status flags: negative, zero, carry and overflow. A 4-bit condition code is tested against the held flags in the same cycle. When the test fails, the instruction is annulled: nothing is written and the flags keep their value.

Arithmetic uses one adder for every form. Subtraction adds the inverted operand, so the carry flag after a subtract means "no borrow". Logical operations take their carry from the shifter and keep the overflow flag as it was. The compare forms change only the flags. Condition code 15 is not a normal conditional form: the block reports it as unsupported and never executes it.

Top module: `flag_alu`

## Requirements
- R1: While rst_ni is low, and after it is released, flags_o reads 0. flags_o is {N,Z,C,V} on bits 3 down to 0.
- R2: op_i encoding: 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN. The add forms work as follows. ADD and CMN give A+B, and ADC gives A+B+C. C is the unsigned carry out of bit 31. V is set when A and B have the same sign and the result's sign differs.
- R3: SUB and CMP give A-B. SBC gives A-B-(1-C). C is 1 when no borrow occurs. V is set when A and B differ in sign and the result's sign differs from A.
- R4: RSB and RSC are SUB and SBC with the operands exchanged: B-A and B-A-(1-C).
- R5: The logical forms are AND, EOR, ORR, BIC (A and not B), MOV (B), MVN (not B), TST and TEQ. When the flags are updated, N is bit 31 of the result and Z is 1 when the result is zero. C takes shift_carry_i, and V keeps its old value.
- R6: flags_o changes at a rising clk_i edge only when valid_i, cond_pass_o and set_flags_i are all 1. It then holds the flags of that cycle's operation.
- R7: TST, TEQ, CMP and CMN (op_i 8 to 11) never raise wr_en_o, but they still update the flags under R6.
- R8: cond_i 0 to 7 pass on Z, !Z, C, !C, N, !N, V and !V, in that order.
- R9: cond_i 8 to 14 pass on C&!Z, !C|Z, N==V, N!=V, !Z&(N==V), Z|(N!=V), and always, in that order.
- R10: cond_i 15 gives cond_pass_o=0 and cond_unsupported_o=1. The instruction writes nothing and changes no flag.
- R11: wr_en_o is 1 exactly when valid_i and cond_pass_o are 1 and op_i is not a compare form. result_o is valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is presented this cycle |
| op_i | input | 4 | Operation code (R2) |
| cond_i | input | 4 | Condition code |
| set_flags_i | input | 1 | Allow a flag update |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Shifted second operand |
| shift_carry_i | input | 1 | Carry out of the shifter |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination write-enable |
| flags_o | output | 4 | Held flags {N,Z,C,V} |
| cond_pass_o | output | 1 | The condition holds on the current flags |
| cond_unsupported_o | output | 1 | The condition code is 15 |

## Verification
The bench sweeps every opcode, condition code, set-flags value and shifter carry over the signed and unsigned boundary operands 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and compares each cycle against an arithmetic model. Several kinds of fault show up in these sweeps. A borrow-polarity error inverts C after every subtract, and a swapped reverse form produces the wrong sign of difference. An overflow rule taken from the adder's raw operands instead of the inverted subtrahend flags V wrongly on 0x80000000-1. A logical form that clears V, or that takes C from the adder, corrupts the flags that the following condition reads. A separate pass forces each reachable flag pattern and walks all sixteen codes. In that pass, a decoder that executes code 15, or that mixes up the signed comparisons, shows as a wrong pass bit or a stray write.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic is_compare(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic is_arith(input logic [3:0] op);
    return (op[3:2] == 2'b01) || (op[3:1] == 3'b001) || (op[3:1] == 3'b101);
  endfunction

  function automatic logic is_reverse(input logic [3:0] op);
    return (op == OP_RSB) || (op == OP_RSC);
  endfunction

  function automatic logic is_subtract(input logic [3:0] op);
    return (op == OP_SUB) || (op == OP_RSB) || (op == OP_SBC) ||
           (op == OP_RSC) || (op == OP_CMP);
  endfunction
endpackage

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         inv_y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] yy;
  logic [W:0]   full;

  assign yy   = inv_y_i ? ~y_i : y_i;
  assign full = {1'b0, x_i} + {1'b0, yy} + {{W{1'b0}}, cin_i};
  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];
  // same-sign inputs to the adder, different-sign sum
  assign ovf_o   = (x_i[W-1] == yy[W-1]) && (full[W-1] != x_i[W-1]);
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic #(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  import flag_alu_pkg::*;

  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MOV:         res_o = b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/flag_alu_cond.sv
module flag_alu_cond (
  input  logic [3:0]           cond_i,
  input  flag_alu_pkg::nzcv_t  flags_i,
  output logic                 pass_o,
  output logic                 unsup_o
);
  logic n, z, c, v;
  assign {n, z, c, v} = flags_i;

  always_comb begin
    unsup_o = 1'b0;
    unique case (cond_i)
      4'h0: pass_o = z;
      4'h1: pass_o = !z;
      4'h2: pass_o = c;
      4'h3: pass_o = !c;
      4'h4: pass_o = n;
      4'h5: pass_o = !n;
      4'h6: pass_o = v;
      4'h7: pass_o = !v;
      4'h8: pass_o = c && !z;
      4'h9: pass_o = !c || z;
      4'hA: pass_o = (n == v);
      4'hB: pass_o = (n != v);
      4'hC: pass_o = !z && (n == v);
      4'hD: pass_o = z || (n != v);
      4'hE: pass_o = 1'b1;
      default: begin
        pass_o  = 1'b0;
        unsup_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [3:0]   cond_i,
  input  logic         set_flags_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         shift_carry_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   flags_o,
  output logic         cond_pass_o,
  output logic         cond_unsupported_o
);
  import flag_alu_pkg::*;

  nzcv_t        flags_q, flags_d;
  logic [W-1:0] x, y, sum, logic_res;
  logic         cin, add_c, add_v, arith, pass, unsup, flag_en;

  // operand routing and carry-in per opcode
  assign x = is_reverse(op_i) ? b_i : a_i;
  assign y = is_reverse(op_i) ? a_i : b_i;

  always_comb begin
    unique case (op_i)
      OP_ADC, OP_SBC, OP_RSC:  cin = flags_q.c;
      OP_SUB, OP_RSB, OP_CMP:  cin = 1'b1;
      default:                 cin = 1'b0;
    endcase
  end

  flag_alu_addsub #(.W(W)) u_addsub (
    .x_i     (x),
    .y_i     (y),
    .inv_y_i (is_subtract(op_i)),
    .cin_i   (cin),
    .sum_o   (sum),
    .carry_o (add_c),
    .ovf_o   (add_v)
  );

  flag_alu_logic #(.W(W)) u_logic (
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (logic_res)
  );

  flag_alu_cond u_cond (
    .cond_i  (cond_i),
    .flags_i (flags_q),
    .pass_o  (pass),
    .unsup_o (unsup)
  );

  assign arith    = is_arith(op_i);
  assign result_o = arith ? sum : logic_res;

  always_comb begin
    flags_d.n = result_o[W-1];
    flags_d.z = ~|result_o;
    flags_d.c = arith ? add_c : shift_carry_i;
    flags_d.v = arith ? add_v : flags_q.v;
  end

  assign flag_en = valid_i && pass && set_flags_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (flag_en) flags_q <= flags_d;
  end

  assign flags_o            = flags_q;
  assign cond_pass_o        = pass;
  assign cond_unsupported_o = unsup;
  assign wr_en_o            = valid_i && pass && !is_compare(op_i);
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [3:0] op_i,
  input logic [3:0] cond_i,
  input logic       set_flags_i,
  input logic       wr_en_o,
  input logic [3:0] flags_o,
  input logic       cond_pass_o,
  input logic       cond_unsupported_o
);
  // R6
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && cond_pass_o && set_flags_i) |=> $stable(flags_o));

  // R7
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[3:2] == 2'b10) |-> !wr_en_o);

  // R10
  cond_f_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'hF) |-> (!cond_pass_o && cond_unsupported_o && !wr_en_o));

  // R9
  cond_always_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'hE) |-> (cond_pass_o && !cond_unsupported_o));

  // R5
  logic_v_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_pass_o && set_flags_i &&
     (op_i inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF}))
    |=> (flags_o[0] == $past(flags_o[0])));

  // R11
  wr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (valid_i && cond_pass_o));
endmodule

bind flag_alu flag_alu_chk u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .valid_i            (valid_i),
  .op_i               (op_i),
  .cond_i             (cond_i),
  .set_flags_i        (set_flags_i),
  .wr_en_o            (wr_en_o),
  .flags_o            (flags_o),
  .cond_pass_o        (cond_pass_o),
  .cond_unsupported_o (cond_unsupported_o)
);

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [3:0]  cond_i = 4'hE;
  logic        set_flags_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        shift_carry_i = 1'b0;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_o;
  logic        cond_pass_o;
  logic        cond_unsupported_o;

  int checks = 0;
  int failures = 0;
  logic [3:0] exp_f = '0;
  string last_tag = "R1";

  always #4 clk_i = ~clk_i;

  flag_alu u_flag_alu (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .cond_i(cond_i), .set_flags_i(set_flags_i), .a_i(a_i), .b_i(b_i),
    .shift_carry_i(shift_carry_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .flags_o(flags_o), .cond_pass_o(cond_pass_o),
    .cond_unsupported_o(cond_unsupported_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (op=%0d cond=%0d a=%h b=%h)",
               tag, act, exp, op_i, cond_i, a_i, b_i);
    end
  endtask

  function automatic logic cond_model(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      0: return z;            1: return !z;
      2: return cy;           3: return !cy;
      4: return n;            5: return !n;
      6: return v;            7: return !v;
      8: return cy && !z;     9: return !cy || z;
      10: return n == v;      11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string op_tag(input logic [3:0] op);
    if (op inside {4'h4, 4'h5, 4'hB}) return "R2";
    if (op inside {4'h2, 4'h6, 4'hA}) return "R3";
    if (op inside {4'h3, 4'h7}) return "R4";
    return "R5";
  endfunction

  // one instruction: drive at negedge, check before the next posedge
  task automatic step(input logic vld, input logic [3:0] op, input logic [3:0] cnd,
                      input logic sf, input logic [31:0] a, input logic [31:0] b,
                      input logic sc);
    logic [31:0] r, x, y;
    logic [33:0] u;
    longint sres;
    logic ci, cy, v, pass, arith, cmp, is_sub;
    logic [3:0] nf;
    @(negedge clk_i);
    valid_i = vld; op_i = op; cond_i = cnd; set_flags_i = sf;
    a_i = a; b_i = b; shift_carry_i = sc;
    #1;
    chk({last_tag, "/R6 flags"}, {28'd0, flags_o}, {28'd0, exp_f});
    pass = cond_model(cnd, exp_f);
    cmp = (op >= 4'h8 && op <= 4'hB);
    arith = op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB};
    is_sub = op inside {4'h2, 4'h3, 4'h6, 4'h7, 4'hA};
    x = (op == 4'h3 || op == 4'h7) ? b : a;
    y = (op == 4'h3 || op == 4'h7) ? a : b;
    ci = (op inside {4'h5, 4'h6, 4'h7}) ? exp_f[1] : is_sub;
    cy = 1'b0; v = 1'b0; r = '0;
    if (arith && !is_sub) begin
      u = {2'b0, x} + {2'b0, y} + {33'd0, ci};
      r = u[31:0]; cy = u[32];
      sres = longint'($signed(x)) + longint'($signed(y)) + longint'(ci);
      v = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
    end else if (is_sub) begin
      r = x - y - {31'd0, !ci};
      cy = ({1'b0, x} >= ({1'b0, y} + {32'd0, !ci}));
      sres = longint'($signed(x)) - longint'($signed(y)) - longint'(!ci);
      v = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
    end else begin
      case (op)
        4'h0, 4'h8: r = a & b;
        4'h1, 4'h9: r = a ^ b;
        4'hC: r = a | b;
        4'hE: r = a & ~b;
        4'hD: r = b;
        default: r = ~b;
      endcase
      cy = sc; v = exp_f[0];
    end
    nf = {r[31], r == 0, cy, v};
    if (cnd != 4'hF) chk((cnd < 8) ? "R8 pass" : "R9 pass", {31'd0, cond_pass_o}, {31'd0, pass});
    else chk("R10 pass", {31'd0, cond_pass_o}, 32'd0);
    chk("R10 unsupported", {31'd0, cond_unsupported_o}, {31'd0, cnd == 4'hF});
    chk(cmp ? "R7 wr_en" : "R11 wr_en", {31'd0, wr_en_o}, {31'd0, vld && pass && !cmp});
    if (vld && pass) chk({op_tag(op), " result"}, result_o, r);
    if (vld && pass && sf) begin
      exp_f = nf; last_tag = op_tag(op);
    end else last_tag = (cnd == 4'hF) ? "R10" : "R6";
  endtask

  initial begin
    repeat (180000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] pats [6];
    int idx;
    pats[0] = 32'h0; pats[1] = 32'h1; pats[2] = 32'h7FFF_FFFF;
    pats[3] = 32'h8000_0000; pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h5A5A_0F0F;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 flags in reset", {28'd0, flags_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 flags after reset", {28'd0, flags_o}, 32'd0);

    // directed corners
    step(1, 4'h4, 4'hE, 1, 32'h7FFF_FFFF, 32'h1, 0);      // R2 signed overflow
    step(1, 4'h2, 4'hE, 1, 32'h8000_0000, 32'h1, 0);      // R3 overflow, no borrow
    step(1, 4'h2, 4'hE, 1, 32'h0, 32'h1, 0);              // R3 borrow -> C=0
    step(1, 4'h3, 4'hE, 1, 32'h5, 32'h3, 0);              // R4 3-5
    step(1, 4'h5, 4'hE, 1, 32'hFFFF_FFFF, 32'h0, 0);      // R2 with C
    step(1, 4'hD, 4'hF, 1, 32'h0, 32'h0, 1);              // R10 ignored
    step(1, 4'hD, 4'hE, 0, 32'h0, 32'h0, 1);              // R6 no set

    // forced flag patterns, every condition code (R8 R9 R10)
    for (int f = 0; f < 16; f++) begin
      if (f[3] && f[2]) continue;
      step(1, 4'h4, 4'hE, 1, f[0] ? 32'h7FFF_FFFF : 32'h0, f[0] ? 32'h1 : 32'h0, 0);
      step(1, 4'hD, 4'hE, 1, 32'h0, f[3] ? 32'h8000_0000 : (f[2] ? 32'h0 : 32'h1), f[1]);
      for (int c = 0; c < 16; c++) step(1, 4'hD, c[3:0], 0, 32'h0, 32'h1234, 0);
    end

    // full sweep
    idx = 0;
    for (int op = 0; op < 16; op++)
      for (int c = 0; c < 16; c++)
        for (int sf = 0; sf < 2; sf++)
          for (int sc = 0; sc < 2; sc++)
            for (int i = 0; i < 6; i++)
              for (int j = 0; j < 6; j++) begin
                idx++;
                step((idx % 7) != 3, op[3:0], c[3:0], sf[0], pats[i], pats[j], sc[0]);
              end
    step(0, 4'h0, 4'hE, 0, 32'h0, 32'h0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule